// File: doc/BRIEF.md
# Unit-Selectable ALU with Sign-Bit Compare Results

This block is a 32-bit arithmetic/logic stage that holds three function units side by side: an adder/subtractor, a magnitude comparator and a per-bit logical unit. A 4-bit unit mask chooses which units take part in an operation, and a shared 5-bit function code configures all of them at once. The result is the bitwise AND of the outputs of every unit in the mask. An empty mask therefore yields a word of all ones. This lets one instruction both compute and mask, for example a compare merged with a logical operation.

The first operand comes either from a register value or from a 6-bit literal, zero-extended to the data width. A compare does not produce a 0/1 flag. It produces a word whose most significant bit holds the truth of the relation and whose other bits are all ones, so a later sign test or AND can use it directly. The comparator picks its answer through a small sense table, indexed by the sign bits of the two operands. The adder raises an overflow-trap request when signed overflow occurs, provided the function code enables it.

Inputs are captured on each rising clock edge. The result and the trap request are registered and show the operation one cycle later. There are no internal states beyond this output register. The block runs the same single path every cycle: capture the inputs, evaluate, register.

Top module: `sel_alu`

## Requirements
- R1: With unit-mask bits [2:0] all zero, the result is all ones. Mask bit 3 is reserved and has no effect on the result or on the trap request.
- R2: When several units are enabled (bit 0 adder, bit 1 comparator, bit 2 logical), the result is the bitwise AND of their individual outputs.
- R3: In the adder, function bit 4 inverts operand A and function bit 0 is the carry-in. The codes give A+B (bit4=0, bit0=0), A+B+1 (0,1), B−A (1,1) and B−A−1 (1,0), all modulo 2^32.
- R4: The trap output is 1 exactly when mask bit 0 is set, function bit 1 is set and the adder's sum overflows as a signed 32-bit number.
- R5: For each bit i, the logical unit outputs function bit [2*A[i]+B[i]]. So code 8 gives AND, E gives OR, 6 gives XOR and C passes A.
- R6: The comparator output has bits 30..0 all ones, and bit 31 equal to the truth of the relation.
- R7: The comparator evaluates the relation A op B as follows: 1A unsigned <, 1B unsigned <=, 15 unsigned >, 14 unsigned >=, 1E signed <, 1F signed <=, 11 signed >, 10 signed >=. Function bit 3 is the sense used when both signs are 1, bit 2 when the signs differ, and bit 1 when both signs are 0.
- R8: When the literal-select input is 1, operand A is the 6-bit literal zero-extended to 32 bits, and the register operand is ignored.
- R9: The result and the trap output are registered. They reflect the inputs present at the previous rising edge. While reset is active, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_sel | input | 4 | Unit mask: bit0 adder, bit1 comparator, bit2 logical, bit3 reserved |
| func | input | 5 | Shared function code |
| use_lit | input | 1 | Take operand A from the literal |
| lit | input | 6 | Literal operand field |
| reg_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Operand B |
| result | output | 32 | Registered AND of the enabled unit outputs |
| ovf_trap | output | 1 | Registered overflow-trap request |

## Verification
Every result and trap request appears on the first rising edge after its inputs were applied, so the latency is one cycle for every unit and every combination of units. The bench drives a new operation on each falling edge and queues the expected word and trap value. One nanosecond after each rising edge, it removes the oldest queued entry and compares it, which keeps expectations in issue order at the fixed latency. Expected compare truths come from native signed and unsigned relational operators. These are applied to all eight codes over pairs of values that straddle the sign boundary and the unsigned wrap point.

// File: rtl/selalu_pkg.sv
package selalu_pkg;
    localparam int unsigned UNIT_W = 4;
    localparam int unsigned FN_W   = 5;

    // Unit-mask bit positions
    localparam int unsigned U_ARITH = 0;
    localparam int unsigned U_CMP   = 1;
    localparam int unsigned U_LOGIC = 2;
    localparam int unsigned U_RSVD  = 3;

    // Function-code bit positions used by the adder and comparator
    localparam int unsigned FB_CIN   = 0;
    localparam int unsigned FB_TRAP  = 1;
    localparam int unsigned FB_INV_A = 4;
endpackage

// File: rtl/selalu_addsub.sv
module selalu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              inv_a,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a_op;

    always_comb begin
        a_op = inv_a ? ~a : a;
        sum  = a_op + b + {{(DATA_W-1){1'b0}}, cin};
        // signed overflow: like-signed inputs, differently signed sum
        ovf  = (a_op[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
    end
endmodule

// File: rtl/selalu_compare.sv
module selalu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [4:0]        fn,
    output logic [DATA_W-1:0] out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a_op;
    logic [DATA_W-1:0] diff;
    logic              same_sign;
    logic              sense;
    logic              base;
    logic              truth;

    always_comb begin
        a_op      = fn[4] ? ~a : a;
        diff      = b + a_op + {{(DATA_W-1){1'b0}}, fn[0]};
        same_sign = (a[MSB] == b[MSB]);
        // sense table indexed by the operand sign pair
        if (same_sign) begin
            sense = a[MSB] ? fn[3] : fn[1];
            base  = diff[MSB];
        end else begin
            sense = fn[2];
            base  = b[MSB];
        end
        truth = base ^ sense;
        out   = {truth, {(DATA_W-1){1'b1}}};
    end
endmodule

// File: rtl/selalu_logic.sv
module selalu_logic #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        tt,
    output logic [DATA_W-1:0] out
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign out[i] = tt[{a[i], b[i]}];
    end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
    import selalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        unit_sel,
    input  logic [4:0]        func,
    input  logic              use_lit,
    input  logic [LIT_W-1:0]  lit,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap
);
    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] unit_out [UNIT_W];
    logic [DATA_W-1:0] combined;
    logic              add_ovf;
    logic              trap_nxt;

    assign a_eff = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : reg_a;

    selalu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a     (a_eff),
        .b     (opnd_b),
        .inv_a (func[FB_INV_A]),
        .cin   (func[FB_CIN]),
        .sum   (unit_out[U_ARITH]),
        .ovf   (add_ovf)
    );

    selalu_compare #(.DATA_W(DATA_W)) u_cmp (
        .a   (a_eff),
        .b   (opnd_b),
        .fn  (func),
        .out (unit_out[U_CMP])
    );

    selalu_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (a_eff),
        .b   (opnd_b),
        .tt  (func[3:0]),
        .out (unit_out[U_LOGIC])
    );

    // reserved unit contributes the AND identity
    assign unit_out[U_RSVD] = '1;

    always_comb begin
        combined = '1;
        for (int u = 0; u < UNIT_W; u++) begin
            if (unit_sel[u]) combined &= unit_out[u];
        end
        trap_nxt = unit_sel[U_ARITH] & func[FB_TRAP] & add_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            ovf_trap <= 1'b0;
        end else begin
            result   <= combined;
            ovf_trap <= trap_nxt;
        end
    end

    AST_EMPTY_MASK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel[2:0] == 3'b000) |=> (result == '1 && !ovf_trap)); // R1
    AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(unit_sel[U_ARITH] && func[FB_TRAP]) |=> !ovf_trap); // R4
    AST_CMP_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel[2:0] == 3'b010) |=> (result[DATA_W-2:0] == '1)); // R6
    AST_LOGIC_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel[2:0] == 3'b100 && func[3:0] == 4'h8 && !use_lit)
        |=> (result == ($past(reg_a) & $past(opnd_b)))); // R5
    AST_LIT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel[2:0] == 3'b100 && func[3:0] == 4'hC && use_lit)
        |=> (result[DATA_W-1:LIT_W] == '0)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !ovf_trap)); // R9
endmodule

// File: tb/sel_alu_test.sv
module sel_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  unit_sel = '0;
    logic [4:0]  func = '0;
    logic        use_lit = 1'b0;
    logic [5:0]  lit = '0;
    logic [31:0] reg_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        ovf_trap;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] r;
        logic        t;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    sel_alu uut (
        .clk(clk), .rst_n(rst_n), .unit_sel(unit_sel), .func(func),
        .use_lit(use_lit), .lit(lit), .reg_a(reg_a), .opnd_b(opnd_b),
        .result(result), .ovf_trap(ovf_trap)
    );

    function automatic logic [31:0] model(input logic [3:0] us, input logic [4:0] fn,
                                          input logic [31:0] a, input logic [31:0] b,
                                          output logic trap);
        logic [31:0] r = '1;
        logic [31:0] part;
        longint      s;
        logic        tr;
        trap = 1'b0;
        if (us[0]) begin
            if (fn[4]) begin
                part = b - a - {31'b0, ~fn[0]};
                s = longint'($signed(b)) - longint'($signed(a)) - (fn[0] ? 0 : 1);
            end else begin
                part = a + b + {31'b0, fn[0]};
                s = longint'($signed(a)) + longint'($signed(b)) + (fn[0] ? 1 : 0);
            end
            trap = fn[1] && (s > 64'sd2147483647 || s < -64'sd2147483648);
            r &= part;
        end
        if (us[1]) begin
            case (fn)
                5'h1A: tr = a < b;
                5'h1B: tr = a <= b;
                5'h15: tr = a > b;
                5'h14: tr = a >= b;
                5'h1E: tr = $signed(a) < $signed(b);
                5'h1F: tr = $signed(a) <= $signed(b);
                5'h11: tr = $signed(a) > $signed(b);
                5'h10: tr = $signed(a) >= $signed(b);
                default: tr = 1'b0;
            endcase
            r &= {tr, 31'h7FFF_FFFF};
        end
        if (us[2]) begin
            for (int i = 0; i < 32; i++) part[i] = fn[{a[i], b[i]}];
            r &= part;
        end
        return r;
    endfunction

    task automatic drive(input logic [3:0] us, input logic [4:0] fn, input logic ul,
                         input logic [5:0] lv, input logic [31:0] ra, input logic [31:0] b,
                         input string tag);
        item_t it;
        logic [31:0] a_eff;
        @(negedge clk);
        unit_sel = us; func = fn; use_lit = ul; lit = lv; reg_a = ra; opnd_b = b;
        a_eff = ul ? {26'b0, lv} : ra;
        it.r = model(us, fn, a_eff, b, it.t);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: results due one cycle after capture
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_chk++;
                if (result !== it.r || ovf_trap !== it.t) begin
                    n_fail++;
                    $display("FAIL %s: result=%h trap=%b expected result=%h trap=%b",
                             it.tag, result, ovf_trap, it.r, it.t);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [6];
        logic [4:0]  codes [8];
        vals  = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                  32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF};
        codes = '{5'h1A, 5'h1B, 5'h15, 5'h14, 5'h1E, 5'h1F, 5'h11, 5'h10};

        // R9 reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (result !== 32'h0 || ovf_trap !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: result=%h trap=%b expected result=0 trap=0", result, ovf_trap);
        end
        rst_n = 1'b1;

        // R1 empty mask, reserved bit ignored
        drive(4'b0000, 5'h03, 0, 0, 32'h7FFF_FFFF, 32'h1, "R1 empty mask");
        drive(4'b1000, 5'h03, 0, 0, 32'h7FFF_FFFF, 32'h1, "R1 reserved only");
        drive(4'b1001, 5'h02, 0, 0, 32'h7FFF_FFFF, 32'h1, "R1 reserved with adder");
        drive(4'b1100, 5'h08, 0, 0, 32'hF0F0_1234, 32'hFF00_FF00, "R1 reserved with logic");

        // R3 adder variants
        drive(4'b0001, 5'h00, 0, 0, 32'd100, 32'd23, "R3 a+b");
        drive(4'b0001, 5'h01, 0, 0, 32'd100, 32'd23, "R3 a+b+1");
        drive(4'b0001, 5'h11, 0, 0, 32'd100, 32'd23, "R3 b-a");
        drive(4'b0001, 5'h10, 0, 0, 32'd100, 32'd23, "R3 b-a-1");
        drive(4'b0001, 5'h00, 0, 0, 32'hFFFF_FFFF, 32'h1, "R3 wrap");

        // R4 trap
        drive(4'b0001, 5'h02, 0, 0, 32'h7FFF_FFFF, 32'h1, "R4 trap on overflow");
        drive(4'b0001, 5'h00, 0, 0, 32'h7FFF_FFFF, 32'h1, "R4 trap disabled");
        drive(4'b0001, 5'h13, 0, 0, 32'h1, 32'h8000_0000, "R4 sub overflow");
        drive(4'b0001, 5'h02, 0, 0, 32'h5, 32'h6, "R4 no overflow");
        drive(4'b0100, 5'h02, 0, 0, 32'h7FFF_FFFF, 32'h1, "R4 adder not selected");

        // R5 logical
        drive(4'b0100, 5'h08, 0, 0, 32'hF0F0_AAAA, 32'hFF00_5555, "R5 and");
        drive(4'b0100, 5'h0E, 0, 0, 32'hF0F0_AAAA, 32'hFF00_5555, "R5 or");
        drive(4'b0100, 5'h06, 0, 0, 32'hF0F0_AAAA, 32'hFF00_5555, "R5 xor");
        drive(4'b0100, 5'h01, 0, 0, 32'hF0F0_AAAA, 32'hFF00_5555, "R5 nor");

        // R2 combined units
        drive(4'b0110, 5'h1A, 0, 0, 32'h1, 32'h8000_00FF, "R2 cmp and logic");
        drive(4'b0011, 5'h11, 0, 0, 32'h10, 32'h0, "R2 adder and cmp");
        drive(4'b0111, 5'h1E, 0, 0, 32'h3, 32'h8000_0007, "R2 three units");

        // R8 literal
        drive(4'b0100, 5'h0C, 1, 6'h2D, 32'hDEAD_BEEF, 32'h0, "R8 literal pass");
        drive(4'b0001, 5'h00, 1, 6'h3F, 32'hFFFF_FFFF, 32'h1, "R8 literal add");
        drive(4'b0010, 5'h1A, 1, 6'h05, 32'hFFFF_FFFF, 32'h6, "R8 literal cmp");

        // R6 R7 compares
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    drive(4'b0010, codes[k], 0, 0, vals[i], vals[j], "R6 R7 compare");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule